// File: doc/BRIEF.md
# Fused multiply-accumulate with full-adder column compression

This block multiplies two small unsigned operands and adds the product into an accumulator register in a single clock step. The operand bits are ANDed into a grid of partial products. The current accumulator bits are dropped into that same grid, one bit per column of matching weight. The grid is then compressed down to one bit per column using nothing but three-input full-adder cells. No separate adder follows the multiplier, and no behavioural multiply or add operator appears in the datapath.

The compression works one column at a time, from the least significant column upward. Inside a column the cells form a chain. Each cell takes the running sum bit and two fresh bits, keeps a new sum bit in the column, and passes a carry bit to the next higher column. When a column holds an even number of bits, one chain input is tied low. Carries out of the top column are discarded, so the arithmetic wraps modulo two to the accumulator width.

A registered wrapper holds the accumulator. The default sizes are 4-bit by 4-bit operands and an 8-bit sum. A synchronous clear has priority over the update, and an enable selects between taking the new sum and holding the old one.

Top module: `mac_acc_unit`

## Requirements
- R1: When `en` is 1 and `clr` is 0, the next `acc_o` after a rising edge of `clk` equals (`acc_o` + `a_i` * `b_i`) mod 2^ACC_W, with both operands read as unsigned integers.
- R2: When `clr` is 1, `acc_o` becomes 0 at the next rising edge, whatever the values of `en`, `a_i` and `b_i` (clear has priority over enable).
- R3: When both `en` and `clr` are 0, `acc_o` keeps its value across rising edges, whatever the operands are.
- R4: While `rst_n` is 0, `acc_o` is 0; the reset acts at once, without waiting for a clock edge.
- R5: A sum that reaches 2^ACC_W or more wraps: the carry out of the top column is dropped, so 225 + 225 gives 194 and 255 + 1 gives 0 for the default sizes.
- R6: An enabled update with `a_i` = 0 or `b_i` = 0 leaves `acc_o` unchanged.
- R7: All 16 x 16 operand pairs, including the full-scale pair 15 x 15 = 225, give the R1 result from arbitrary prior accumulator values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low, clears the accumulator |
| clr | input | 1 | Synchronous clear of the accumulator, overrides `en` |
| en | input | 1 | Add the product of the operands into the accumulator at the next edge |
| a_i | input | A_W | First unsigned operand |
| b_i | input | B_W | Second unsigned operand |
| acc_o | output | ACC_W | Accumulator value |

## Verification
On every cycle, the bound properties check how the register chooses between clear, hold and load. They also check that a zero operand adds nothing. A further pair of properties ties the dropped top-column carry to the accumulator: when the carry is set, the accumulator goes down, and when it is clear, the accumulator does not. The exact arithmetic of the compression network can only be shown by the bench scenarios: every operand pair from random starting sums, the exact wrap points, and a long random mix of clear, enable and idle cycles. The asynchronous reset is also observed only by the bench.

// File: rtl/mac_pkg.sv
package mac_pkg;

    localparam int MAC_A_W   = 4;
    localparam int MAC_B_W   = 4;
    localparam int MAC_ACC_W = 8;

    // lowest row index i whose partial product a[i]&b[c-i] lands in column c
    function automatic int pp_lo(int c, int bw);
        return (c - bw + 1 > 0) ? (c - bw + 1) : 0;
    endfunction

    // number of partial-product bits of weight 2^c
    function automatic int pp_in_col(int c, int aw, int bw);
        int n = 0;
        for (int i = 0; i < aw; i++) begin
            if ((c - i >= 0) && (c - i < bw)) n++;
        end
        return n;
    endfunction

    // bits entering column c: partial products, one accumulator bit,
    // and every carry produced by the chain of column c-1
    function automatic int bits_in_col(int c, int aw, int bw);
        int k = 0;
        int n = 0;
        for (int i = 0; i <= c; i++) begin
            n = pp_in_col(i, aw, bw) + 1 + k;
            k = n / 2;
        end
        return n;
    endfunction

    // full-adder cells in the chain of column c (even heights get a tied-low input)
    function automatic int fa_in_col(int c, int aw, int bw);
        return bits_in_col(c, aw, bw) / 2;
    endfunction

endpackage

// File: rtl/mac_fa_cell.sv
module mac_fa_cell (
    input  logic a_i,
    input  logic b_i,
    input  logic c_i,
    output logic s_o,
    output logic co_o
);

    // count of three equal-weight bits: low bit stays, high bit moves up a column
    assign s_o  = a_i ^ b_i ^ c_i;
    assign co_o = (a_i & b_i) | (a_i & c_i) | (b_i & c_i);

endmodule

// File: rtl/mac_pp_gen.sv
module mac_pp_gen #(
    parameter int A_W = 4,
    parameter int B_W = 4
) (
    input  logic [A_W-1:0]     a_i,
    input  logic [B_W-1:0]     b_i,
    output logic [A_W*B_W-1:0] pp_o
);

    // pp_o[i*B_W + j] carries weight 2^(i+j)
    for (genvar i = 0; i < A_W; i++) begin : g_row
        for (genvar j = 0; j < B_W; j++) begin : g_bit
            assign pp_o[i*B_W + j] = a_i[i] & b_i[j];
        end
    end

endmodule

// File: rtl/mac_col_tree.sv
module mac_col_tree
    import mac_pkg::*;
#(
    parameter int A_W   = 4,
    parameter int B_W   = 4,
    parameter int ACC_W = 8
) (
    input  logic [A_W*B_W-1:0] pp_i,
    input  logic [ACC_W-1:0]   acc_i,
    output logic [ACC_W-1:0]   sum_o,
    output logic               wrap_o
);

    for (genvar c = 0; c < ACC_W; c++) begin : g_col
        localparam int NPP = pp_in_col(c, A_W, B_W);
        localparam int NB  = bits_in_col(c, A_W, B_W);
        localparam int NFA = NB / 2;
        localparam int LO  = pp_lo(c, B_W);

        logic [2*NFA:0] bits;
        logic [NFA-1:0] s;
        logic [NFA-1:0] co;

        // column layout: partial products, accumulator bit, carries from below, pad
        for (genvar k = 0; k <= 2*NFA; k++) begin : g_bit
            if (k < NPP) begin : g_pp
                assign bits[k] = pp_i[(LO + k)*B_W + (c - LO - k)];
            end else if (k == NPP) begin : g_acc
                assign bits[k] = acc_i[c];
            end else if (k < NB) begin : g_cy
                assign bits[k] = g_col[c-1].co[k - NPP - 1];
            end else begin : g_pad
                assign bits[k] = 1'b0;
            end
        end

        // chain of 3:2 cells: each folds two fresh bits into the running sum bit
        for (genvar j = 0; j < NFA; j++) begin : g_fa
            logic x;
            if (j == 0) begin : g_first
                assign x = bits[0];
            end else begin : g_next
                assign x = s[j-1];
            end
            mac_fa_cell u_fa (
                .a_i  (x),
                .b_i  (bits[2*j + 1]),
                .c_i  (bits[2*j + 2]),
                .s_o  (s[j]),
                .co_o (co[j])
            );
        end

        assign sum_o[c] = s[NFA-1];
    end

    // weight 2^ACC_W carries are dropped from the sum; flag them for observation
    assign wrap_o = |g_col[ACC_W-1].co;

endmodule

// File: rtl/mac_acc_unit.sv
module mac_acc_unit
    import mac_pkg::*;
#(
    parameter int A_W   = MAC_A_W,
    parameter int B_W   = MAC_B_W,
    parameter int ACC_W = MAC_ACC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic [A_W-1:0]   a_i,
    input  logic [B_W-1:0]   b_i,
    output logic [ACC_W-1:0] acc_o
);

    localparam int PP_N = A_W * B_W;

    typedef struct packed {
        logic [ACC_W-1:0] acc;
    } state_t;

    state_t            st_d;
    state_t            st_q;
    logic [PP_N-1:0]   pp_w;
    logic [ACC_W-1:0]  sum_w;
    logic              wrap_w;

    mac_pp_gen #(
        .A_W (A_W),
        .B_W (B_W)
    ) u_pp (
        .a_i  (a_i),
        .b_i  (b_i),
        .pp_o (pp_w)
    );

    mac_col_tree #(
        .A_W   (A_W),
        .B_W   (B_W),
        .ACC_W (ACC_W)
    ) u_tree (
        .pp_i   (pp_w),
        .acc_i  (st_q.acc),
        .sum_o  (sum_w),
        .wrap_o (wrap_w)
    );

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.acc = '0;
        end else if (en) begin
            st_d.acc = sum_w;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_o = st_q.acc;

endmodule

// File: rtl/mac_acc_checker.sv
module mac_acc_checker #(
    parameter int A_W   = 4,
    parameter int B_W   = 4,
    parameter int ACC_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clr,
    input logic             en,
    input logic [A_W-1:0]   a_i,
    input logic [B_W-1:0]   b_i,
    input logic [ACC_W-1:0] acc_o,
    input logic [ACC_W-1:0] sum_i,
    input logic             wrap_i
);

    // R2: clear wins over everything
    p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (acc_o == '0));

    // R3: idle cycles keep the accumulator
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !en) |=> $stable(acc_o));

    // R1: an enabled cycle stores the compressed sum
    p_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && en) |=> (acc_o == $past(sum_i)));

    // R6: a zero operand contributes nothing to the compression result
    p_zero_op_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((a_i == '0) || (b_i == '0)) |-> (sum_i == acc_o));

    // R5: a dropped top carry means the stored value went down
    p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && en && wrap_i) |=> (acc_o < $past(acc_o)));

    // R5: without a dropped carry the stored value never goes down
    p_nowrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && en && !wrap_i) |=> (acc_o >= $past(acc_o)));

endmodule

bind mac_acc_unit mac_acc_checker #(
    .A_W   (A_W),
    .B_W   (B_W),
    .ACC_W (ACC_W)
) u_mac_acc_checker (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (clr),
    .en     (en),
    .a_i    (a_i),
    .b_i    (b_i),
    .acc_o  (acc_o),
    .sum_i  (sum_w),
    .wrap_i (wrap_w)
);

// File: tb/test_mac_acc_unit.sv
module test_mac_acc_unit;

    localparam int A_W   = 4;
    localparam int B_W   = 4;
    localparam int ACC_W = 8;
    localparam int MOD   = 1 << ACC_W;
    localparam int AMOD  = 1 << A_W;
    localparam int BMOD  = 1 << B_W;

    logic             clk   = 1'b0;
    logic             rst_n = 1'b0;
    logic             clr   = 1'b0;
    logic             en    = 1'b0;
    logic [A_W-1:0]   a     = '0;
    logic [B_W-1:0]   b     = '0;
    logic [ACC_W-1:0] acc;

    int n_chk  = 0;
    int n_fail = 0;
    int model  = 0;

    always #5 clk = ~clk;

    mac_acc_unit #(
        .A_W   (A_W),
        .B_W   (B_W),
        .ACC_W (ACC_W)
    ) i_mac_acc_unit (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .en    (en),
        .a_i   (a),
        .b_i   (b),
        .acc_o (acc)
    );

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: acc_o=%0d expected %0d", tag, act, exp);
        end
    endtask

    // drive at a falling edge, let one rising edge pass, sample at the next falling edge
    task automatic step(bit c, bit e, int x, int y, string tag, bit do_chk);
        clr = c;
        en  = e;
        a   = A_W'(x);
        b   = B_W'(y);
        @(posedge clk);
        if (c) model = 0;
        else if (e) model = (model + (x % AMOD) * (y % BMOD)) % MOD;
        @(negedge clk);
        if (do_chk) check(tag, int'(acc), model);
    endtask

    task automatic t_reset_state();
        repeat (3) @(negedge clk);
        check("R4 held in reset", int'(acc), 0);
        rst_n = 1'b1;
        model = 0;
        step(0, 0, 15, 15, "R4 after release", 1);
    endtask

    task automatic t_clear();
        step(0, 1, 11, 7, "R1 load 77", 1);
        step(1, 1, 15, 15, "R2 clear with enable high", 1);
        step(0, 1, 3, 5, "R1 load 15", 1);
        step(1, 0, 9, 9, "R2 clear with enable low", 1);
    endtask

    task automatic t_hold();
        step(0, 1, 13, 6, "R1 load 78", 1);
        for (int i = 0; i < 4; i++) begin
            step(0, 0, 15 - i, 2 + i, "R3 hold", 1);
        end
    endtask

    task automatic t_zero();
        step(1, 0, 0, 0, "R2 clear", 0);
        step(0, 1, 12, 10, "R1 load 120", 1);
        step(0, 1, 0, 13, "R6 a zero", 1);
        step(0, 1, 9, 0, "R6 b zero", 1);
        step(0, 1, 0, 0, "R6 both zero", 1);
    endtask

    task automatic t_wrap();
        step(1, 0, 0, 0, "R2 clear", 0);
        step(0, 1, 15, 15, "R7 full scale 225", 1);
        step(0, 1, 15, 15, "R5 225+225 wraps to 194", 1);
        check("R5 value 194", int'(acc), 194);
        step(1, 0, 0, 0, "R2 clear", 0);
        step(0, 1, 15, 15, "R7 full scale 225", 1);
        step(0, 1, 15, 2, "R5 reach 255", 1);
        check("R5 value 255", int'(acc), 255);
        step(0, 1, 1, 1, "R5 255+1 wraps to 0", 1);
        check("R5 value 0", int'(acc), 0);
    endtask

    task automatic t_all_pairs();
        for (int x = 0; x < AMOD; x++) begin
            for (int y = 0; y < BMOD; y++) begin
                step(1, 0, 0, 0, "R2 clear", 0);
                step(0, 1, $urandom_range(0, 15), $urandom_range(0, 15), "preload", 0);
                step(0, 1, $urandom_range(0, 15), $urandom_range(0, 15), "preload", 0);
                step(0, 1, x, y, "R7 operand pair", 1);
            end
        end
    endtask

    task automatic t_async_reset();
        step(0, 1, 7, 9, "R1 load before reset", 1);
        rst_n = 1'b0;
        #2;
        check("R4 asynchronous reset", int'(acc), 0);
        model = 0;
        @(negedge clk);
        rst_n = 1'b1;
        step(0, 0, 0, 0, "R4 stays zero", 1);
    endtask

    task automatic t_random_mix();
        for (int i = 0; i < 2000; i++) begin
            int r = $urandom_range(0, 15);
            step(r == 0, r > 3, $urandom_range(0, 15), $urandom_range(0, 15),
                 "R1 R2 R3 random mix", 1);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual running expected finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        t_reset_state();
        t_clear();
        t_hold();
        t_zero();
        t_wrap();
        t_all_pairs();
        t_async_reset();
        t_random_mix();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule